// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block manages the packet store of an Ethernet controller. The store is cut into 256-byte pages. The host takes pages by asking for a packet number together with a number of extra pages. The block hands out the lowest free packet number and records which pages belong to that number in a per-page ownership table, so the granted pages do not have to be contiguous. The host can later return all pages of a packet in one step. The block does not move any frame bytes; it only does the accounting of pages and packet numbers.

Two queues of packet numbers sit next to the page table. The host puts a finished transmit frame on the transmit queue. When the MAC reports that a frame has gone out, the head of the queue moves into a completion register and a transmit flag rises. The MAC pushes received packet numbers onto the receive queue. The host polls the empty flag of that queue, reads the head and then releases it, which frees its pages.

There is one command port. A command is taken in one cycle and takes effect in the next one. Busy is high during that second cycle, and any command presented while busy is high is dropped.

Top module: `pkt_page_mmu`

## Requirements
- R1: A command is accepted when `cmd_valid` is high on a clock edge where `busy` is low. `busy` is then high for exactly the following cycle. A command presented while `busy` is high is ignored. The effect of an accepted command shows on the outputs after the edge that ends the busy cycle.
- R2: Command codes on `cmd_op`: 1 allocate, 2 clear-all, 3 enqueue, 4 free, 5 release. Codes 0, 6 and 7 change nothing.
- R3: An allocate with `cmd_arg` = n (0..7) needs n+1 pages. It takes the lowest free packet number and the n+1 lowest-indexed free pages. `alloc_result` becomes {1'b0, packet number}, and `free_pages` drops by n+1.
- R4: An allocate fails when n exceeds 7, when fewer than n+1 pages are free, or when every packet number is in use. On failure `alloc_result` becomes 8'h80 (bit 7 set, low seven bits zero) and no page or packet number changes state.
- R5: `alloc_irq` sets on every completed allocate, whether it succeeded or failed. It stays set until a cycle with `alloc_ack` high. If the set and the acknowledge fall in the same cycle, the set wins.
- R6: A free of `cmd_pkt` returns all pages of that packet, and its number becomes available to later allocates. A free of an unallocated number, or of a number at or above NUM_PKTS, has no effect.
- R7: An enqueue appends `cmd_pkt` (if below NUM_PKTS) to the transmit queue. A push is ignored if the queue already holds NUM_PKTS entries. A `tx_done` pulse on a non-empty queue moves the oldest entry to `done_pkt` and sets `tx_irq`. `tx_irq` holds until `tx_ack`, and a set wins over a same-cycle acknowledge. `tx_done` on an empty queue is ignored.
- R8: `rx_push` appends `rx_pkt` (which must be below NUM_PKTS) to the receive queue, unless the queue is full. `rx_empty` shows whether the queue holds nothing, and `rx_head` shows its oldest entry. A release frees the pages of the head packet and removes it. A release on an empty queue has no effect.
- R9: A clear-all command makes every page free and every packet number unallocated, and empties both queues. A `tx_done` or `rx_push` in the same cycle is dropped. `alloc_result`, `done_pkt` and the two flags keep their values.
- R10: While `rst_n` is low: `busy` is low, `free_pages` equals NUM_PAGES, both queues are empty, both flags are clear, and `alloc_result` and `done_pkt` are zero.
- R11: A push and a pop on the same queue in the same cycle both take effect, in first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | 4 | Extra page count for allocate |
| cmd_pkt | input | 7 | Packet number for enqueue and free |
| busy | output | 1 | Command in progress |
| alloc_result | output | 8 | Fail bit 7, packet number in bits 6:0 |
| alloc_irq | output | 1 | Allocate-complete flag |
| alloc_ack | input | 1 | Clears `alloc_irq` |
| free_pages | output | 8 | Number of free pages |
| tx_done | input | 1 | MAC finished the head transmit frame |
| tx_ack | input | 1 | Clears `tx_irq` |
| tx_irq | output | 1 | Transmit-complete flag |
| done_pkt | output | 7 | Packet number of the last completed transmit |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | MAC appends a received packet |
| rx_pkt | input | 7 | Received packet number |
| rx_empty | output | 1 | Receive queue empty |
| rx_head | output | 7 | Oldest received packet number |

## Verification
The host command path and the MAC-side queue strobes run independently, so a queue can be pushed and popped in the same cycle. Examples are an enqueue executing while `tx_done` pops the head, or a release executing while `rx_push` appends. The bench provokes these by raising the MAC strobe exactly in the busy cycle of the command. It then compares the queue order, `done_pkt`, `rx_head` and `free_pages` cycle by cycle against a behavioural model built on queues. The same timing is used to place `alloc_ack` on the allocate completion edge and a MAC push on a clear-all; the model predicts the set-wins and drop outcomes.

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu #(
  parameter int NUM_PAGES = 18,
  parameter int NUM_PKTS  = 8,
  parameter int MAX_EXTRA = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [3:0] cmd_arg,
  input  logic [6:0] cmd_pkt,
  output logic       busy,
  output logic [7:0] alloc_result,
  output logic       alloc_irq,
  input  logic       alloc_ack,
  output logic [7:0] free_pages,
  input  logic       tx_done,
  input  logic       tx_ack,
  output logic       tx_irq,
  output logic [6:0] done_pkt,
  output logic       tx_empty,
  input  logic       rx_push,
  input  logic [6:0] rx_pkt,
  output logic       rx_empty,
  output logic [6:0] rx_head
);
  localparam int PW = $clog2(NUM_PKTS);
  localparam int QW = $clog2(NUM_PKTS + 1);
  localparam logic [2:0] OP_ALLOC = 3'd1, OP_CLR = 3'd2, OP_ENQ = 3'd3,
                         OP_FREE = 3'd4, OP_REL = 3'd5;

  logic          pend;
  logic [2:0]    p_op;
  logic [3:0]    p_arg;
  logic [6:0]    p_pkt;

  logic [NUM_PAGES-1:0] pg_used;
  logic [PW-1:0]        pg_own [NUM_PAGES];
  logic [NUM_PKTS-1:0]  pk_used;

  logic [PW-1:0] txq [NUM_PKTS];
  logic [PW-1:0] rxq [NUM_PKTS];
  logic [PW-1:0] tx_rd, tx_wr, rx_rd, rx_wr;
  logic [QW-1:0] tx_cnt, rx_cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(NUM_PKTS - 1)) ? '0 : p + 1'b1;
  endfunction

  wire is_alloc = pend && p_op == OP_ALLOC;
  wire is_clr   = pend && p_op == OP_CLR;
  wire is_enq   = pend && p_op == OP_ENQ;
  wire is_free  = pend && p_op == OP_FREE;
  wire is_rel   = pend && p_op == OP_REL;
  wire in_rng   = p_pkt < 7'(NUM_PKTS);

  wire [7:0] need_pg = {4'd0, p_arg} + 8'd1;
  wire [7:0] free_cnt = 8'($countones(~pg_used));

  logic [PW-1:0] slot;
  logic          slot_ok;
  always_comb begin
    slot = '0;
    slot_ok = 1'b0;
    for (int k = NUM_PKTS - 1; k >= 0; k--)
      if (!pk_used[k]) begin
        slot = PW'(k);
        slot_ok = 1'b1;
      end
  end

  wire alloc_ok = is_alloc && (p_arg <= 4'(MAX_EXTRA)) && slot_ok && (free_cnt >= need_pg);

  logic [NUM_PAGES-1:0] grab;
  always_comb begin
    logic [7:0] taken;
    taken = 8'd0;
    grab = '0;
    for (int p = 0; p < NUM_PAGES; p++)
      if (!pg_used[p] && taken < need_pg) begin
        grab[p] = 1'b1;
        taken = taken + 8'd1;
      end
  end

  wire           tx_pop  = tx_done && tx_cnt != '0 && !is_clr;
  wire           tx_push = is_enq && in_rng && tx_cnt != QW'(NUM_PKTS);
  wire           rx_pop  = is_rel && rx_cnt != '0;
  wire           rx_psh  = rx_push && rx_cnt != QW'(NUM_PKTS) && !is_clr;
  wire [PW-1:0]  victim  = is_free ? p_pkt[PW-1:0] : rxq[rx_rd];
  wire           do_free = (is_free && in_rng && pk_used[p_pkt[PW-1:0]]) || rx_pop;

  logic [NUM_PAGES-1:0] fmask;
  always_comb
    for (int p = 0; p < NUM_PAGES; p++)
      fmask[p] = do_free && pg_used[p] && pg_own[p] == victim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= 1'b0;
      p_op <= '0;
      p_arg <= '0;
      p_pkt <= '0;
    end else begin
      pend <= cmd_valid && !pend;
      if (cmd_valid && !pend) begin
        p_op <= cmd_op;
        p_arg <= cmd_arg;
        p_pkt <= cmd_pkt;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg_used <= '0;
      pk_used <= '0;
    end else if (is_clr) begin
      pg_used <= '0;
      pk_used <= '0;
    end else begin
      pg_used <= (pg_used | (alloc_ok ? grab : '0)) & ~fmask;
      if (alloc_ok) pk_used[slot] <= 1'b1;
      if (do_free) pk_used[victim] <= 1'b0;
    end

  always_ff @(posedge clk)
    for (int p = 0; p < NUM_PAGES; p++)
      if (alloc_ok && grab[p]) pg_own[p] <= slot;

  always_ff @(posedge clk) begin
    if (tx_push) txq[tx_wr] <= p_pkt[PW-1:0];
    if (rx_psh) rxq[rx_wr] <= rx_pkt[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
      rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
    end else if (is_clr) begin
      tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
      rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
    end else begin
      if (tx_pop) tx_rd <= nxt(tx_rd);
      if (tx_push) tx_wr <= nxt(tx_wr);
      tx_cnt <= tx_cnt + QW'(tx_push) - QW'(tx_pop);
      if (rx_pop) rx_rd <= nxt(rx_rd);
      if (rx_psh) rx_wr <= nxt(rx_wr);
      rx_cnt <= rx_cnt + QW'(rx_psh) - QW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      alloc_result <= '0;
      alloc_irq <= 1'b0;
      tx_irq <= 1'b0;
      done_pkt <= '0;
    end else begin
      if (is_alloc) alloc_result <= alloc_ok ? {1'b0, 7'(slot)} : 8'h80;
      if (is_alloc) alloc_irq <= 1'b1;
      else if (alloc_ack) alloc_irq <= 1'b0;
      if (tx_pop) begin
        done_pkt <= 7'(txq[tx_rd]);
        tx_irq <= 1'b1;
      end else if (tx_ack) tx_irq <= 1'b0;
    end

  assign busy       = pend;
  assign free_pages = free_cnt;
  assign tx_empty   = tx_cnt == '0;
  assign rx_empty   = rx_cnt == '0;
  assign rx_head    = 7'(rxq[rx_rd]);

  p_busy_one_r1: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !busy);
  p_fail_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_result[7] |-> alloc_result[6:0] == 7'd0);
  p_grant_pages_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alloc_irq) && !alloc_result[7] |-> free_pages < $past(free_pages));
  p_airq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_irq && !alloc_ack |=> alloc_irq);
  p_tirq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq && !tx_ack |=> tx_irq);
  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && p_op == OP_CLR |=> free_pages == 8'(NUM_PAGES) && tx_empty && rx_empty);
endmodule

// File: tb/pkt_page_mmu_tb.sv
module pkt_page_mmu_tb;
  localparam int NPG = 18;
  localparam int NPK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, alloc_ack = 0, tx_done = 0, tx_ack = 0, rx_push = 0;
  logic [2:0] cmd_op = 0;
  logic [3:0] cmd_arg = 0;
  logic [6:0] cmd_pkt = 0, rx_pkt = 0;
  logic busy, alloc_irq, tx_irq, tx_empty, rx_empty;
  logic [7:0] alloc_result, free_pages;
  logic [6:0] done_pkt, rx_head;

  always #2.5 clk = ~clk;

  pkt_page_mmu u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_pkt(cmd_pkt), .busy(busy),
    .alloc_result(alloc_result), .alloc_irq(alloc_irq), .alloc_ack(alloc_ack),
    .free_pages(free_pages), .tx_done(tx_done), .tx_ack(tx_ack), .tx_irq(tx_irq),
    .done_pkt(done_pkt), .tx_empty(tx_empty), .rx_push(rx_push), .rx_pkt(rx_pkt),
    .rx_empty(rx_empty), .rx_head(rx_head));

  int vectors = 0, miscompares = 0;
  string req = "R10";

  int m_own [NPG];
  bit m_used [NPK];
  int txq [$];
  int rxq [$];
  bit m_pend;
  int m_op, m_arg, m_pkt, m_res, m_done;
  bit m_airq, m_tirq;

  task automatic model_clear();
    for (int p = 0; p < NPG; p++) m_own[p] = -1;
    for (int k = 0; k < NPK; k++) m_used[k] = 0;
    txq.delete();
    rxq.delete();
  endtask

  task automatic drop_pkt(int v);
    for (int p = 0; p < NPG; p++) if (m_own[p] == v) m_own[p] = -1;
    m_used[v] = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
      m_pend = 0; m_res = 0; m_done = 0; m_airq = 0; m_tirq = 0;
    end else begin
      int tx_n, rx_n, nfree, slot, need, v;
      bit clr, tpop, tpush, rpop, rpsh;
      tx_n = txq.size();
      rx_n = rxq.size();
      clr = m_pend && m_op == 2;
      if (m_pend && m_op == 1) begin
        need = m_arg + 1;
        nfree = 0;
        for (int p = 0; p < NPG; p++) if (m_own[p] < 0) nfree++;
        slot = -1;
        for (int k = NPK - 1; k >= 0; k--) if (!m_used[k]) slot = k;
        if (m_arg <= 7 && slot >= 0 && nfree >= need) begin
          m_used[slot] = 1;
          for (int p = 0; p < NPG; p++)
            if (m_own[p] < 0 && need > 0) begin m_own[p] = slot; need--; end
          m_res = slot;
        end else m_res = 'h80;
        m_airq = 1;
      end else if (alloc_ack) m_airq = 0;
      if (m_pend && m_op == 4 && m_pkt < NPK && m_used[m_pkt]) drop_pkt(m_pkt);
      rpop = m_pend && m_op == 5 && rx_n > 0;
      rpsh = rx_push && rx_n < NPK && !clr;
      tpop = tx_done && tx_n > 0 && !clr;
      tpush = m_pend && m_op == 3 && m_pkt < NPK && tx_n < NPK;
      if (rpop) begin v = rxq.pop_front(); drop_pkt(v); end
      if (rpsh) rxq.push_back(int'(rx_pkt));
      if (tpop) begin m_done = txq.pop_front(); m_tirq = 1; end
      else if (tx_ack) m_tirq = 0;
      if (tpush) txq.push_back(m_pkt);
      if (clr) model_clear();
      m_pend = cmd_valid && !m_pend;
      if (m_pend) begin m_op = cmd_op; m_arg = cmd_arg; m_pkt = cmd_pkt; end
    end
  end

  task automatic chk(string name, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int nfree;
    nfree = 0;
    for (int p = 0; p < NPG; p++) if (m_own[p] < 0) nfree++;
    vectors++;
    chk("busy", busy, m_pend);
    chk("alloc_result", alloc_result, m_res);
    chk("alloc_irq", alloc_irq, m_airq);
    chk("free_pages", free_pages, nfree);
    chk("tx_irq", tx_irq, m_tirq);
    chk("done_pkt", done_pkt, m_done);
    chk("tx_empty", tx_empty, txq.size() == 0);
    chk("rx_empty", rx_empty, rxq.size() == 0);
    if (rxq.size() > 0) chk("rx_head", rx_head, rxq[0]);
  end

  // side bits: 3 rx_push, 2 tx_done, 1 tx_ack, 0 alloc_ack
  task automatic set_side(logic [3:0] s);
    rx_push = s[3]; tx_done = s[2]; tx_ack = s[1]; alloc_ack = s[0];
  endtask

  task automatic issue(int op, int arg, int pkt, logic [3:0] side = 4'd0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_arg = 4'(arg); cmd_pkt = 7'(pkt);
    @(negedge clk);
    cmd_valid = 0;
    set_side(side);
    @(negedge clk);
    set_side(4'd0);
  endtask

  task automatic pulse(logic [3:0] side);
    @(negedge clk);
    set_side(side);
    @(negedge clk);
    set_side(4'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R10";
    chk("reset free_pages", free_pages, NPG);
    chk("reset busy", busy, 0);
    chk("reset rx_empty", rx_empty, 1);
    chk("reset alloc_result", alloc_result, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    req = "R3";
    issue(1, 0, 0);
    issue(1, 2, 0);
    req = "R4";
    issue(1, 9, 0);
    req = "R3";
    issue(1, 7, 0);
    req = "R4";
    issue(1, 6, 0);
    req = "R3";
    issue(1, 5, 0);
    req = "R5";
    pulse(4'b0001);
    issue(1, 0, 0, 4'b0001);
    pulse(4'b0001);
    req = "R1";
    @(negedge clk);
    cmd_valid = 1; cmd_op = 4; cmd_pkt = 1;
    @(negedge clk);
    cmd_op = 2;
    @(negedge clk);
    cmd_valid = 0;
    @(negedge clk);
    req = "R6";
    issue(4, 0, 1);
    issue(4, 0, 100);
    req = "R2";
    issue(6, 0, 0);
    issue(7, 3, 2);
    issue(0, 1, 0);
    req = "R6";
    issue(1, 1, 0);
    req = "R7";
    issue(3, 0, 0);
    issue(3, 0, 2);
    issue(3, 0, 3);
    pulse(4'b0100);
    pulse(4'b0010);
    req = "R11";
    issue(3, 0, 1, 4'b0100);
    req = "R7";
    pulse(4'b0110);
    pulse(4'b0100);
    pulse(4'b0100);
    pulse(4'b0010);
    for (int i = 0; i < 9; i++) issue(3, 0, i % NPK);
    for (int i = 0; i < 10; i++) pulse(4'b0100);
    req = "R8";
    rx_pkt = 2; pulse(4'b1000);
    rx_pkt = 3; pulse(4'b1000);
    issue(5, 0, 0);
    req = "R11";
    rx_pkt = 1; issue(5, 0, 0, 4'b1000);
    req = "R8";
    issue(5, 0, 0);
    issue(5, 0, 0);
    req = "R9";
    rx_pkt = 0; pulse(4'b1000);
    issue(3, 0, 0);
    issue(2, 0, 0, 4'b1100);
    req = "R4";
    for (int i = 0; i < 9; i++) issue(1, 0, 0);
    req = "R11";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cmd_valid = 1'($urandom_range(0, 1));
      cmd_op = 3'($urandom_range(0, 7));
      cmd_arg = 4'($urandom_range(0, 9));
      cmd_pkt = 7'($urandom_range(0, 9));
      rx_pkt = 7'($urandom_range(0, NPK - 1));
      set_side(4'($urandom_range(0, 15)));
    end
    @(negedge clk);
    cmd_valid = 0;
    set_side(4'd0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule